// File: doc/BRIEF.md
# Warp Lane Issue Sequencer

This block sits at the front of a narrow SIMD execution array. It keeps a set of resident warp contexts, each holding a program counter and a ready flag. For every new instruction it picks one ready warp, then feeds that warp's 32 threads into an 8-lane array as four slices on four back-to-back cycles. During each slice it presents the warp number, the slice index, the instruction's PC, the thread number carried by each lane and a lane-valid mask.

Any ready warp may be chosen for each new instruction. Because of this, a warp that is waiting on memory can be skipped by clearing its ready flag, and other work fills the lanes in the meantime. Selection rotates round-robin, starting after the warp issued most recently. After the last slice of an instruction the PC of that warp steps forward by one instruction word (4). The ready flags are set and cleared through masks, and a PC can be loaded for any context.

Top module: `warp_issue_seq`

## Requirements
- R1: After synchronous reset, issue_valid, busy and every lane_valid bit are 0. Every ready flag and PC is 0. The round-robin pointer is set so that warp 0 has first priority.
- R2: When the sequencer is free, it selects the first ready warp found by searching upward from the last issued warp plus one, wrapping from 23 to 0. The last issued warp itself is reached only after all the others.
- R3: Each instruction occupies exactly 4 consecutive cycles with issue_slice 0, 1, 2, 3. issue_warp and issue_pc stay constant across those cycles.
- R4: In slice k, lane j carries thread 8k+j. Lane j's thread number is field lane_tid[5j+4:5j].
- R5: lane_valid is 8'hFF and issue_valid is 1 in every issuing cycle. Both are 0 when nothing is issued.
- R6: busy is 1 in slices 0 to 2 and 0 in slice 3 and when idle. A new selection is made only on an edge where busy is 0, so consecutive instructions follow with no gap.
- R7: After the fourth slice, the PC of the warp that issued increases by 4. If that same warp is selected at that same edge, it already issues with the increased PC.
- R8: Clearing a warp's ready flag while its instruction is in progress does not stop the remaining slices.
- R9: When no ready flag is set, nothing is issued.
- R10: A ready flag is updated at the edge where ready_set or ready_clr is applied, and a clear wins over a set of the same warp. The first slice of a warp made ready by a set appears one edge later.
- R11: pc_load_en writes pc_load_val into context pc_load_id, overriding the step of R7. Any selection at that edge or later issues with the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_set | input | 24 | Per-warp mask that sets ready flags |
| ready_clr | input | 24 | Per-warp mask that clears ready flags (wins over set) |
| pc_load_en | input | 1 | Load a context PC |
| pc_load_id | input | 5 | Context written by a PC load |
| pc_load_val | input | 32 | PC value written |
| issue_valid | output | 1 | A slice is being issued this cycle |
| issue_warp | output | 5 | Warp being issued |
| issue_pc | output | 32 | PC of the instruction being issued |
| issue_slice | output | 2 | Slice index within the instruction |
| lane_tid | output | 40 | Thread number per lane, 5 bits per lane, lane 0 lowest |
| lane_valid | output | 8 | Per-lane valid mask |
| busy | output | 1 | More slices of the current instruction remain |

## Verification
A slice counter that slips shows up within one instruction as a wrong issue_slice, wrong lane thread numbers, or an early or late busy drop. A corrupted round-robin pointer becomes visible on the very next selection as an unexpected issue_warp. A missed or doubled PC step stays hidden until the same warp issues again. For that reason the bench reissues warps and runs one warp back to back, where the step must show up in the cycle right after slice 3. A ready flag that fails to clear appears four cycles later as an extra instruction instead of idle lanes.

// File: rtl/wlis_pkg.sv
package wlis_pkg;
    localparam int NUM_WARPS = 24;
    localparam int LANES     = 8;
    localparam int WARP_SIZE = 32;
    localparam int PC_W      = 32;
    localparam int PC_STEP   = 4;

    localparam int SLICES  = WARP_SIZE / LANES;
    localparam int WID_W   = $clog2(NUM_WARPS);
    localparam int SLICE_W = (SLICES > 1) ? $clog2(SLICES) : 1;
    localparam int TID_W   = $clog2(WARP_SIZE);

    typedef logic [WID_W-1:0]   wid_t;
    typedef logic [PC_W-1:0]    pc_t;
    typedef logic [SLICE_W-1:0] slice_t;
    typedef logic [TID_W-1:0]   tid_t;

    localparam slice_t LAST_SLICE = slice_t'(SLICES - 1);
    localparam wid_t   TOP_WARP   = wid_t'(NUM_WARPS - 1);

    // State of the instruction currently on the lanes
    typedef struct packed {
        logic   active;
        wid_t   warp;
        pc_t    pc;
        slice_t slice;
    } issue_s;

    function automatic tid_t thread_of(slice_t s, int lane);
        return tid_t'(int'(s) * LANES + lane);
    endfunction

    function automatic pc_t pc_next(pc_t p);
        return p + pc_t'(PC_STEP);
    endfunction
endpackage

// File: rtl/wlis_ctx.sv
module wlis_ctx
    import wlis_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] ready_set,
    input  logic [NUM_WARPS-1:0] ready_clr,
    input  logic                 pc_load_en,
    input  wid_t                 pc_load_id,
    input  pc_t                  pc_load_val,
    input  logic                 adv_en,
    input  wid_t                 adv_id,
    input  wid_t                 rd_id,
    output logic [NUM_WARPS-1:0] ready_q,
    output pc_t                  rd_pc
);
    pc_t pc_mem [NUM_WARPS];

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ctx
        localparam wid_t MY_ID = wid_t'(w);

        always_ff @(posedge clk) begin
            if (rst)               ready_q[w] <= 1'b0;
            else if (ready_clr[w]) ready_q[w] <= 1'b0;
            else if (ready_set[w]) ready_q[w] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst)
                pc_mem[w] <= '0;
            else if (pc_load_en && pc_load_id == MY_ID)
                pc_mem[w] <= pc_load_val;
            else if (adv_en && adv_id == MY_ID)
                pc_mem[w] <= pc_next(pc_mem[w]);
        end
    end

    // Read port forwards a same-edge write so a selection never sees a stale PC
    always_comb begin
        if (pc_load_en && pc_load_id == rd_id)
            rd_pc = pc_load_val;
        else if (adv_en && adv_id == rd_id)
            rd_pc = pc_next(pc_mem[rd_id]);
        else
            rd_pc = pc_mem[rd_id];
    end
endmodule

// File: rtl/wlis_arb.sv
module wlis_arb
    import wlis_pkg::*;
(
    input  logic [NUM_WARPS-1:0] req,
    input  wid_t                 last_id,
    output logic                 gnt_valid,
    output wid_t                 gnt_id
);
    always_comb begin
        int idx;
        gnt_valid = 1'b0;
        gnt_id    = '0;
        for (int i = 1; i <= NUM_WARPS; i++) begin
            idx = (int'(last_id) + i) % NUM_WARPS;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_id    = wid_t'(idx);
            end
        end
    end
endmodule

// File: rtl/wlis_slicer.sv
module wlis_slicer
    import wlis_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   gnt_valid,
    input  wid_t                   gnt_id,
    input  pc_t                    gnt_pc,
    output issue_s                 st,
    output wid_t                   last_id,
    output logic                   busy,
    output logic                   done,
    output logic [LANES*TID_W-1:0] lane_tid,
    output logic [LANES-1:0]       lane_valid
);
    assign busy = st.active && (st.slice != LAST_SLICE);
    assign done = st.active && (st.slice == LAST_SLICE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            last_id <= TOP_WARP;
        end else if (!busy) begin
            if (gnt_valid) begin
                st.active <= 1'b1;
                st.warp   <= gnt_id;
                st.pc     <= gnt_pc;
                st.slice  <= '0;
                last_id   <= gnt_id;
            end else begin
                st <= '0;
            end
        end else begin
            st.slice <= st.slice + 1'b1;
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_tid[j*TID_W +: TID_W] = st.active ? thread_of(st.slice, j) : '0;
        assign lane_valid[j]              = st.active;
    end
endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
    import wlis_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_WARPS-1:0]   ready_set,
    input  logic [NUM_WARPS-1:0]   ready_clr,
    input  logic                   pc_load_en,
    input  logic [WID_W-1:0]       pc_load_id,
    input  logic [PC_W-1:0]        pc_load_val,
    output logic                   issue_valid,
    output logic [WID_W-1:0]       issue_warp,
    output logic [PC_W-1:0]        issue_pc,
    output logic [SLICE_W-1:0]     issue_slice,
    output logic [LANES*TID_W-1:0] lane_tid,
    output logic [LANES-1:0]       lane_valid,
    output logic                   busy
);
    logic [NUM_WARPS-1:0] ready_q;
    logic                 gnt_valid;
    wid_t                 gnt_id;
    wid_t                 last_id;
    pc_t                  gnt_pc;
    issue_s               st;
    logic                 done;

    wlis_ctx u_ctx (
        .clk         (clk),
        .rst         (rst),
        .ready_set   (ready_set),
        .ready_clr   (ready_clr),
        .pc_load_en  (pc_load_en),
        .pc_load_id  (pc_load_id),
        .pc_load_val (pc_load_val),
        .adv_en      (done),
        .adv_id      (st.warp),
        .rd_id       (gnt_id),
        .ready_q     (ready_q),
        .rd_pc       (gnt_pc)
    );

    wlis_arb u_arb (
        .req       (ready_q),
        .last_id   (last_id),
        .gnt_valid (gnt_valid),
        .gnt_id    (gnt_id)
    );

    wlis_slicer u_slicer (
        .clk        (clk),
        .rst        (rst),
        .gnt_valid  (gnt_valid),
        .gnt_id     (gnt_id),
        .gnt_pc     (gnt_pc),
        .st         (st),
        .last_id    (last_id),
        .busy       (busy),
        .done       (done),
        .lane_tid   (lane_tid),
        .lane_valid (lane_valid)
    );

    assign issue_valid = st.active;
    assign issue_warp  = st.warp;
    assign issue_pc    = st.pc;
    assign issue_slice = st.slice;
endmodule

// File: rtl/warp_issue_seq_chk.sv
module warp_issue_seq_chk
    import wlis_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   pc_load_en,
    input logic                   issue_valid,
    input logic [WID_W-1:0]       issue_warp,
    input logic [PC_W-1:0]        issue_pc,
    input logic [SLICE_W-1:0]     issue_slice,
    input logic [LANES*TID_W-1:0] lane_tid,
    input logic [LANES-1:0]       lane_valid,
    input logic                   busy
);
    // Set when a PC load happened during the current instruction
    logic load_seen;
    always_ff @(posedge clk) begin
        if (rst)                       load_seen <= 1'b0;
        else if (pc_load_en)           load_seen <= 1'b1;
        else if (issue_valid && !busy) load_seen <= 1'b0;
    end

    assert_slice_step_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && busy) |=> (issue_valid && issue_slice == $past(issue_slice) + 1'b1
                                   && $stable(issue_warp) && $stable(issue_pc)));

    assert_start_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !busy) |=> (!issue_valid || issue_slice == '0));

    assert_lane0_tid_R4: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (lane_tid[TID_W-1:0] == tid_t'(int'(issue_slice) * LANES)));

    assert_lane_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid ? (lane_valid == '1) : (lane_valid == '0)));

    assert_idle_nobusy_R6: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> !busy);

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !busy && !pc_load_en && !load_seen) |=>
        (!issue_valid || issue_warp != $past(issue_warp)
         || issue_pc == $past(issue_pc) + pc_t'(PC_STEP)));

    assert_warp_range_R2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (int'(issue_warp) < NUM_WARPS));
endmodule

bind warp_issue_seq warp_issue_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_load_en  (pc_load_en),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_pc    (issue_pc),
    .issue_slice (issue_slice),
    .lane_tid    (lane_tid),
    .lane_valid  (lane_valid),
    .busy        (busy)
);

// File: tb/warp_issue_seq_test.sv
module warp_issue_seq_test;
    import wlis_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NUM_WARPS-1:0]   ready_set = '0;
    logic [NUM_WARPS-1:0]   ready_clr = '0;
    logic                   pc_load_en = 1'b0;
    logic [WID_W-1:0]       pc_load_id = '0;
    logic [PC_W-1:0]        pc_load_val = '0;
    logic                   issue_valid;
    logic [WID_W-1:0]       issue_warp;
    logic [PC_W-1:0]        issue_pc;
    logic [SLICE_W-1:0]     issue_slice;
    logic [LANES*TID_W-1:0] lane_tid;
    logic [LANES-1:0]       lane_valid;
    logic                   busy;

    int checks = 0;
    int fails  = 0;
    int issued [NUM_WARPS];

    always #10 clk = ~clk;

    warp_issue_seq uut (.*);

    // Each row: ready mask to apply, expected warp selected
    localparam int NVEC = 8;
    localparam logic [NUM_WARPS+WID_W-1:0] VEC [NVEC] = '{
        {24'h000001, 5'd0},
        {24'h000021, 5'd5},
        {24'h000028, 5'd3},
        {24'h800000, 5'd23},
        {24'h800001, 5'd0},
        {24'hFFFFFF, 5'd1},
        {24'h000002, 5'd1},
        {24'h101000, 5'd12}
    };

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint base_pc(int w);
        return longint'(w) * 256;
    endfunction

    // Checks one slice of warp w at index k (called at a negedge)
    task automatic check_slice(int w, longint pc, int k, bit more);
        check("R5 issue_valid", issue_valid, 1);
        check("R5 lane_valid", lane_valid, 8'hFF);
        check("R3 warp", issue_warp, w);
        check("R3 pc", issue_pc, pc);
        check("R3 slice", issue_slice, k);
        check("R6 busy", busy, more);
        for (int j = 0; j < LANES; j++)
            check("R4 lane tid", lane_tid[j*TID_W +: TID_W], k * LANES + j);
    endtask

    task automatic check_idle(string req);
        check(req, issue_valid, 0);
        check(req, lane_valid, 0);
        check(req, busy, 0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int w = 0; w < NUM_WARPS; w++) issued[w] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_idle("R1 reset idle");

        // R11: load a PC into each context
        for (int w = 0; w < NUM_WARPS; w++) begin
            pc_load_en  = 1'b1;
            pc_load_id  = WID_W'(w);
            pc_load_val = PC_W'(base_pc(w));
            @(negedge clk);
        end
        pc_load_en = 1'b0;
        @(negedge clk);
        check_idle("R9 no ready idle");

        // Table walk: R2 selection order, R3/R4/R5/R6 slicing, R7 PC step, R8 clear mid-flight
        for (int v = 0; v < NVEC; v++) begin
            int w;
            longint pc;
            w  = int'(VEC[v][WID_W-1:0]);
            pc = base_pc(w) + 4 * issued[w];
            ready_set = VEC[v][NUM_WARPS+WID_W-1:WID_W];
            @(negedge clk);
            ready_set = '0;
            check("R10 no issue before set seen", issue_valid, 0);
            @(negedge clk);
            check("R2 selected warp", issue_warp, w);
            check_slice(w, pc, 0, 1'b1);
            ready_clr = '1;
            @(negedge clk);
            ready_clr = '0;
            check_slice(w, pc, 1, 1'b1);
            @(negedge clk);
            check_slice(w, pc, 2, 1'b1);
            @(negedge clk);
            check_slice(w, pc, 3, 1'b0);
            issued[w]++;
            @(negedge clk);
            check_idle("R8 idle after cleared");
            repeat (2) @(negedge clk);
        end

        // R7 + R6: warp 7 back to back with no gap; R8: clear during second instruction
        ready_set = 24'h000080;
        @(negedge clk);
        ready_set = '0;
        @(negedge clk);
        for (int k = 0; k < SLICES; k++) begin
            check_slice(7, base_pc(7), k, k != SLICES - 1);
            @(negedge clk);
        end
        check_slice(7, base_pc(7) + 4, 0, 1'b1);
        ready_clr = 24'h000080;
        @(negedge clk);
        ready_clr = '0;
        for (int k = 1; k < SLICES; k++) begin
            check_slice(7, base_pc(7) + 4, k, k != SLICES - 1);
            @(negedge clk);
        end
        check_idle("R8 R9 idle after back to back");

        // R10: clear wins over set of the same warp
        ready_set = 24'h000200;
        ready_clr = 24'h000200;
        @(negedge clk);
        ready_set = '0;
        ready_clr = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_idle("R10 clear over set");
        end

        // R11: new PC loaded into warp 3 is used at its next issue
        pc_load_en  = 1'b1;
        pc_load_id  = 5'd3;
        pc_load_val = 32'h0000_1000;
        ready_set   = 24'h000008;
        @(negedge clk);
        pc_load_en = 1'b0;
        ready_set  = '0;
        @(negedge clk);
        check("R11 loaded pc", issue_pc, 32'h0000_1000);
        check("R2 warp after load", issue_warp, 3);
        ready_clr = '1;
        @(negedge clk);
        ready_clr = '0;
        repeat (4) @(negedge clk);
        check_idle("R9 final idle");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule